// File: doc/BRIEF.md
# Parallel Frequency-Word Byte Loader

This block sits on the host side of a direct digital synthesizer. It sends the synthesizer's 40-bit tuning word over an 8-bit parallel load port. A single-cycle start request captures the word. The block then presents the word as five bytes, most significant first. For each byte it first lets the data settle, then raises a byte-load strobe. The receiver latches the byte on that rising edge. The block then drops the strobe again while keeping the data steady. After the last byte it raises and lowers a separate commit strobe, which makes the receiver apply the new tuning word.

The timing of each phase is set by parameters in clock cycles: how long data settles before a strobe rises, how long a strobe stays high, and how long the low phase after a strobe lasts. The block reports a busy level while a transfer runs. It reports a one-cycle completion pulse when the transfer ends, and the host may start the next transfer in that same cycle.

Top module: `dds_word_loader`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, byteStrobe and commitStrobe are 0 and busBytes is 8'h00.
- R2: A start seen high at a clock edge while idle captures wordIn at that edge, and busy is 1 from the next cycle on.
- R3: The word goes out as exactly five bytes. Byte k (k = 0..4) equals wordIn[39-8k -: 8], so bits 39:32 go first and bits 7:0 go last.
- R4: Each byte is on busBytes for SETUP_CYC cycles (default 2) with byteStrobe low before byteStrobe rises. The first byte appears in the first cycle after start is accepted.
- R5: byteStrobe stays high for PULSE_CYC cycles (default 2). It is then low for HOLD_CYC cycles (default 1), and busBytes does not change from the start of setup until the low phase ends.
- R6: After the fifth byte's low phase, commitStrobe is high for PULSE_CYC cycles and then low for HOLD_CYC cycles. The two strobes are never high together, and both are low when idle.
- R7: done is 1 for exactly one cycle, in the cycle right after the commit low phase, and busy is 0 in that same cycle. A transfer therefore spans 5*(SETUP_CYC+PULSE_CYC+HOLD_CYC)+PULSE_CYC+HOLD_CYC busy cycles.
- R8: A start while busy is ignored, even if wordIn changes. The running transfer keeps its captured bytes and its timing.
- R9: A start given in the done cycle is accepted, and the next transfer begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Transfer request, sampled when idle |
| wordIn | input | 40 | Tuning word to send |
| busBytes | output | 8 | Byte presented on the parallel load port |
| byteStrobe | output | 1 | Byte-load strobe; the receiver latches on its rising edge |
| commitStrobe | output | 1 | Commit strobe; its rising edge applies the loaded word |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The bench compares every output against an arithmetic cycle model in every cycle of every transfer. A wrong byte counter therefore shows on the port within one byte period: as a sixth or fourth byte strobe, or as a commit strobe that comes early or late. A wrong phase count shows in the first cycle where a strobe's timing differs from the model. A corrupted shadow register or shift shows as a wrong byte in the cycle that byte appears. The bench also asserts start at varied cycles inside transfers, with a different word, so that any leak of start or wordIn into a running transfer changes the output within the cycles that follow.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_WHI   = 3'd2,
    ST_WLO   = 3'd3,
    ST_FHI   = 3'd4,
    ST_FLO   = 3'd5
  } ldState_t;

  typedef struct packed {
    logic capture;
    logic advance;
  } dpCmd_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/dds_loader_dp.sv
module dds_loader_dp
  import dds_loader_pkg::*;
#(
  parameter int BYTES  = 5,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  dpCmd_t                    cmd,
  input  logic [BYTES*BYTE_W-1:0]   wordIn,
  output logic [BYTE_W-1:0]         busByte
);

  localparam int WORD_W = BYTES * BYTE_W;

  logic [WORD_W-1:0] shadow;

  generate
    if (BYTES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          shadow <= '0;
        end else if (cmd.capture) begin
          shadow <= wordIn;
        end else if (cmd.advance) begin
          shadow <= {shadow[WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          shadow <= '0;
        end else if (cmd.capture) begin
          shadow <= wordIn;
        end
      end
    end
  endgenerate

  assign busByte = shadow[WORD_W-1 -: BYTE_W];

endmodule

// File: rtl/dds_loader_ctrl.sv
module dds_loader_ctrl
  import dds_loader_pkg::*;
#(
  parameter int BYTES     = 5,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output dpCmd_t cmd,
  output logic   byteStrobe,
  output logic   commitStrobe,
  output logic   busy,
  output logic   done
);

  localparam int MAX_LEN = maxOf3(SETUP_CYC, PULSE_CYC, HOLD_CYC);
  localparam int PH_W    = $clog2(MAX_LEN + 1);
  localparam int BIDX_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [PH_W-1:0]   SETUP_END = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0]   PULSE_END = PH_W'(PULSE_CYC - 1);
  localparam logic [PH_W-1:0]   HOLD_END  = PH_W'(HOLD_CYC - 1);
  localparam logic [BIDX_W-1:0] LAST_IDX  = BIDX_W'(BYTES - 1);

  ldState_t          state, stateNext;
  logic [PH_W-1:0]   phaseCnt;
  logic [BIDX_W-1:0] byteIdx;
  logic              phaseEnd;
  logic              lastByte;
  logic              doneR;

  always_comb begin
    case (state)
      ST_SETUP: phaseEnd = (phaseCnt == SETUP_END);
      ST_WHI:   phaseEnd = (phaseCnt == PULSE_END);
      ST_FHI:   phaseEnd = (phaseCnt == PULSE_END);
      ST_WLO:   phaseEnd = (phaseCnt == HOLD_END);
      ST_FLO:   phaseEnd = (phaseCnt == HOLD_END);
      default:  phaseEnd = 1'b0;
    endcase
  end

  assign lastByte = (byteIdx == LAST_IDX);

  always_comb begin
    stateNext   = state;
    cmd.capture = 1'b0;
    cmd.advance = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stateNext   = ST_SETUP;
          cmd.capture = 1'b1;
        end
      end
      ST_SETUP: if (phaseEnd) stateNext = ST_WHI;
      ST_WHI:   if (phaseEnd) stateNext = ST_WLO;
      ST_WLO: begin
        if (phaseEnd) begin
          if (lastByte) begin
            stateNext = ST_FHI;
          end else begin
            stateNext   = ST_SETUP;
            cmd.advance = 1'b1;
          end
        end
      end
      ST_FHI:   if (phaseEnd) stateNext = ST_FLO;
      ST_FLO:   if (phaseEnd) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      byteIdx  <= '0;
      doneR    <= 1'b0;
    end else begin
      state <= stateNext;
      doneR <= (state == ST_FLO) && phaseEnd;
      if (state == ST_IDLE || phaseEnd) begin
        phaseCnt <= '0;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
      if (cmd.capture) begin
        byteIdx <= '0;
      end else if (cmd.advance) begin
        byteIdx <= byteIdx + 1'b1;
      end
    end
  end

  assign byteStrobe   = (state == ST_WHI);
  assign commitStrobe = (state == ST_FHI);
  assign busy         = (state != ST_IDLE);
  assign done         = doneR;

endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
  import dds_loader_pkg::*;
#(
  parameter int BYTES     = 5,
  parameter int BYTE_W    = 8,
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [BYTES*BYTE_W-1:0] wordIn,
  output logic [BYTE_W-1:0]       busBytes,
  output logic                    byteStrobe,
  output logic                    commitStrobe,
  output logic                    busy,
  output logic                    done
);

  dpCmd_t dpCmd;

  dds_loader_ctrl #(
    .BYTES     (BYTES),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .cmd          (dpCmd),
    .byteStrobe   (byteStrobe),
    .commitStrobe (commitStrobe),
    .busy         (busy),
    .done         (done)
  );

  dds_loader_dp #(
    .BYTES  (BYTES),
    .BYTE_W (BYTE_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .cmd     (dpCmd),
    .wordIn  (wordIn),
    .busByte (busBytes)
  );

endmodule

// File: rtl/dds_loader_checker.sv
module dds_loader_checker #(
  parameter int BYTES     = 5,
  parameter int BYTE_W    = 8,
  parameter int PULSE_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] busBytes,
  input logic              byteStrobe,
  input logic              commitStrobe,
  input logic              busy,
  input logic              done
);

  int   byteHiRun;
  int   commitHiRun;
  int   risesSeen;
  logic prevByte;
  logic prevCommit;

  always_ff @(posedge clk) begin
    if (rst) begin
      byteHiRun   <= 0;
      commitHiRun <= 0;
      risesSeen   <= 0;
      prevByte    <= 1'b0;
      prevCommit  <= 1'b0;
    end else begin
      prevByte   <= byteStrobe;
      prevCommit <= commitStrobe;
      if (byteStrobe) byteHiRun <= prevByte ? byteHiRun + 1 : 1;
      if (commitStrobe) commitHiRun <= prevCommit ? commitHiRun + 1 : 1;
      if (done) risesSeen <= 0;
      else if (byteStrobe && !prevByte) risesSeen <= risesSeen + 1;
    end
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(byteStrobe && commitStrobe)); // R6

  AST_BUS_HELD_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $fell(byteStrobe) |-> $stable(busBytes)); // R5

  AST_BYTE_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(byteStrobe) |-> (byteHiRun == PULSE_CYC)); // R5

  AST_COMMIT_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(commitStrobe) |-> (commitHiRun == PULSE_CYC)); // R6

  AST_COMMIT_AFTER_ALL_BYTES: assert property (@(posedge clk) disable iff (rst)
    $rose(commitStrobe) |-> (risesSeen == BYTES)); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R7

  AST_IDLE_STROBES_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!byteStrobe && !commitStrobe)); // R6

endmodule

bind dds_word_loader dds_loader_checker #(
  .BYTES     (BYTES),
  .BYTE_W    (BYTE_W),
  .PULSE_CYC (PULSE_CYC)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busBytes     (busBytes),
  .byteStrobe   (byteStrobe),
  .commitStrobe (commitStrobe),
  .busy         (busy),
  .done         (done)
);

// File: tb/dds_word_loader_bench.sv
module dds_word_loader_bench;

  localparam int CLK_PERIOD = 10;
  localparam int S    = 2;
  localparam int P    = 2;
  localparam int H    = 1;
  localparam int NB   = 5;
  localparam int T    = S + P + H;
  localparam int LAST = NB * T + P + H;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [39:0] wordIn = '0;
  logic [7:0]  busBytes;
  logic        byteStrobe, commitStrobe, busy, done;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_word_loader u_dds_word_loader (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .wordIn       (wordIn),
    .busBytes     (busBytes),
    .byteStrobe   (byteStrobe),
    .commitStrobe (commitStrobe),
    .busy         (busy),
    .done         (done)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Compare all outputs in cycle k of a transfer of word w (k=0 is the
  // first cycle after the accepting edge).
  task automatic checkCycle(input int k, input logic [39:0] w);
    logic expByte, expCommit, expBusy, expDone;
    logic [7:0] expBus;
    expByte = 0; expCommit = 0; expBusy = 1; expDone = 0; expBus = 8'h00;
    if (k < NB * T) begin
      int b, r;
      b = k / T;
      r = k % T;
      expByte = (r >= S) && (r < S + P);
      expBus  = w[39 - 8*b -: 8];
      chk("R3", "busBytes", 64'(busBytes), 64'(expBus));
      chk(expByte ? "R5" : "R4", "byteStrobe", 64'(byteStrobe), 64'(expByte));
    end else begin
      int k2;
      k2 = k - NB * T;
      expCommit = (k2 < P);
      expBusy   = (k2 < P + H);
      expDone   = (k2 == P + H);
      chk("R5", "busBytes held", 64'(busBytes), 64'(w[7:0]));
      chk("R6", "byteStrobe", 64'(byteStrobe), 64'(1'b0));
    end
    chk("R6", "commitStrobe", 64'(commitStrobe), 64'(expCommit));
    chk(k == 0 ? "R2" : "R7", "busy", 64'(busy), 64'(expBusy));
    chk("R7", "done", 64'(done), 64'(expDone));
  endtask

  // Entered at a negedge; leaves at the negedge of the done cycle.
  task automatic runFrame(input logic [39:0] w, input int injectAt);
    start  = 1'b1;
    wordIn = w;
    @(negedge clk);
    for (int k = 0; k <= LAST; k++) begin
      checkCycle(k, w);
      if (k < LAST) begin
        start  = (k == injectAt);   // R8: ignored while busy
        wordIn = (k == injectAt) ? ~w : w;
        @(negedge clk);
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL R7 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [39:0] w;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", 64'(busy), 64'(0));
    chk("R1", "byteStrobe in reset", 64'(byteStrobe), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy", 64'(busy), 64'(0));
    chk("R1", "done", 64'(done), 64'(0));
    chk("R1", "byteStrobe", 64'(byteStrobe), 64'(0));
    chk("R1", "commitStrobe", 64'(commitStrobe), 64'(0));
    chk("R1", "busBytes", 64'(busBytes), 64'(0));

    runFrame(40'h01_23_45_67_89, -1);
    @(negedge clk);
    runFrame(40'hFF_FF_FF_FF_FF, 3);
    @(negedge clk);
    runFrame(40'h00_00_00_00_00, 10);
    @(negedge clk);

    // Walking one across the word, injecting an ignored start at a sweeping
    // offset inside the transfer (R8).
    for (int i = 0; i < 40; i++) begin
      w = 40'd1 << i;
      runFrame(w, i % LAST);
      @(negedge clk);
    end

    // Back-to-back transfers started in the done cycle (R9).
    runFrame(40'hA5_5A_C3_3C_81, LAST - 1);
    runFrame(40'h80_00_00_00_01, 0);
    runFrame(40'h7E_DB_24_96_E1, -1);

    // Idle with start low: nothing moves (R6, R7).
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R6", "idle byteStrobe", 64'(byteStrobe), 64'(0));
      chk("R6", "idle commitStrobe", 64'(commitStrobe), 64'(0));
      chk("R7", "idle done", 64'(done), 64'(0));
      chk("R7", "idle busy", 64'(busy), 64'(0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule